// File: doc/BRIEF.md
# Double-Buffered Co-processor Buffer Wrapper

This block wraps a streaming processing element in a uniform shell with two ways in: a flat data port, through which the rest of the node can both read and write every word of the internal buffer memory, and a small command port that starts a processing pass and reports when it finishes. The buffer memory is split into equal banks. The lower half of the banks are input banks and the upper half are output banks. On the engine side, each input bank offers only a read port and each output bank offers only a write port. The external side of every bank is a full read/write port.

A pass is started only after software has completely loaded an input bank. The start command names a pair of input banks. Inside that pair, the wrapper alternates between the two banks on successive starts. A pass reads every word of the chosen input bank, applies the placeholder stage (an increment modulo 2^DATA_W), and writes the result to the same word of the matching output bank (input bank b goes to output bank NUM_IN+b). While one bank is being processed, the external port can freely fill or drain the other banks. This overlap is the double-buffering scheme. A start that arrives while a pass is running is rejected and flagged. An external write into the input bank under processing raises a sticky collision flag.

Top module: `coproc_buf_wrapper`

## Requirements
- R1: After reset, ctl_busy, ctl_done, ctl_err and ctl_collision are all 0.
- R2: The external address is {bank, word}, with the bank in the upper BANK_AW bits and the word in the lower WORD_AW bits. A write stores data in that word. A read (ext_en=1, ext_we=0) presents that word on ext_rdata after the next rising edge.
- R3: An external write changes only the addressed word. Every other word of every bank keeps its contents.
- R4: A pass on input bank b writes, for every word index i, the value (in[b][i] + 1) mod 2^DATA_W to word i of output bank NUM_IN+b.
- R5: Starts name a pair p through ctl_pair. Accepted starts on pair p alternate between input banks 2p and 2p+1, beginning with 2p after reset. Each pair keeps its own alternation. ctl_done_bank shows the input bank of the last pass.
- R6: Once a start is accepted at an edge, ctl_busy is 1 for exactly BANK_WORDS+1 cycles. ctl_done is a one-cycle pulse in the first cycle with ctl_busy back at 0.
- R7: A start while ctl_busy is 1 is ignored. It pulses ctl_err for one cycle, does not advance the alternation of any pair, and does not disturb the running pass.
- R8: An external write into the input bank under processing while ctl_busy is 1 sets ctl_collision, which then stays 1 until reset. Writes to other banks do not set it.
- R9: External reads and writes to banks other than the one under processing complete normally during a pass.
- R10: A pass writes no output bank other than NUM_IN+b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_en | input | 1 | External access request |
| ext_we | input | 1 | External access is a write |
| ext_addr | input | ADDR_W | Flat buffer address {bank, word} |
| ext_wdata | input | DATA_W | External write data |
| ext_rdata | output | DATA_W | External read data, one cycle after the request |
| ctl_start | input | 1 | Start a pass on the pair given by ctl_pair |
| ctl_pair | input | PAIR_W | Input bank pair for the start |
| ctl_busy | output | 1 | A pass is running |
| ctl_done | output | 1 | One-cycle pulse at the end of a pass |
| ctl_done_bank | output | IN_W | Input bank of the latest pass |
| ctl_err | output | 1 | One-cycle pulse: a start was rejected |
| ctl_collision | output | 1 | Sticky: external write hit the bank being processed |

## Verification
Every word of all eight banks is loaded with a distinct arithmetic pattern and read back. This separates faulty bank decoding and word decoding from crosstalk between banks. Passes are run in sequence on both pairs, including a repeat pass on the same bank, so the per-pair alternation is tested separately from a single shared pointer. After each pass, the full set of output banks is compared. One input word is all ones, so the increment must wrap to zero. A rejected start, an overlapping write into an idle bank, and a write into the active bank show the difference between the error, overlap and collision behaviours.

// File: rtl/coproc_buf_pkg.sv
package coproc_buf_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_RUN   = 2'd1,
    ENG_FLUSH = 2'd2
  } eng_state_e;
endpackage

// File: rtl/coproc_in_bank.sv
module coproc_in_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [AW-1:0]     a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic [AW-1:0]     b_addr,
  output logic [DATA_W-1:0] b_rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // external side: read/write
  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      else      a_rdata     <= mem[a_addr];
    end
  end

  // engine side: read only
  always_ff @(posedge clk) begin
    if (b_en) b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/coproc_out_bank.sv
module coproc_out_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [AW-1:0]     a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_we,
  input  logic [AW-1:0]     b_addr,
  input  logic [DATA_W-1:0] b_wdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // both sides share one process; the engine write takes the later slot
  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      else      a_rdata     <= mem[a_addr];
    end
    if (b_we) mem[b_addr] <= b_wdata;
  end
endmodule

// File: rtl/coproc_engine.sv
module coproc_engine
  import coproc_buf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int NUM_IN = 4,
  localparam int AW     = $clog2(DEPTH),
  localparam int IN_W   = $clog2(NUM_IN),
  localparam int NPAIR  = NUM_IN / 2,
  localparam int PAIR_W = $clog2(NPAIR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAIR_W-1:0] pair,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [IN_W-1:0]   bank,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  eng_state_e        state_q, state_d;
  logic [AW-1:0]     idx_q, idx_d;
  logic [IN_W-1:0]   bank_q, bank_d;
  logic              bank_en;
  logic              v1_q;
  logic [AW-1:0]     widx_q;
  logic [NPAIR-1:0]  ptr_q, ptr_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              accept;

  assign busy    = (state_q != ENG_IDLE);
  assign accept  = start && !busy;
  assign rd_en   = (state_q == ENG_RUN);
  assign rd_addr = idx_q;
  assign wr_en   = v1_q;
  assign wr_addr = widx_q;
  assign wr_data = rd_data + DATA_W'(1);
  assign bank    = bank_q;
  assign done    = done_q;
  assign err     = err_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    bank_d  = bank_q;
    bank_en = 1'b0;
    ptr_d   = ptr_q;
    done_d  = 1'b0;
    err_d   = start && busy;
    unique case (state_q)
      ENG_IDLE: begin
        if (accept) begin
          state_d     = ENG_RUN;
          idx_d       = '0;
          bank_en     = 1'b1;
          bank_d      = {pair, ptr_q[pair]};
          ptr_d[pair] = ~ptr_q[pair];
        end
      end
      ENG_RUN: begin
        idx_d = idx_q + AW'(1);
        if (idx_q == LAST_IDX) state_d = ENG_FLUSH;
      end
      ENG_FLUSH: begin
        state_d = ENG_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      idx_q   <= '0;
      bank_q  <= '0;
      v1_q    <= 1'b0;
      widx_q  <= '0;
      ptr_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (bank_en) bank_q <= bank_d;
      v1_q    <= rd_en;
      if (rd_en) widx_q <= idx_q;
      ptr_q   <= ptr_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end
endmodule

// File: rtl/coproc_buf_wrapper.sv
module coproc_buf_wrapper #(
  parameter int DATA_W     = 32,
  parameter int BANK_WORDS = 16,
  parameter int NUM_IN     = 4,
  localparam int WORD_AW   = $clog2(BANK_WORDS),
  localparam int NUM_BANKS = 2 * NUM_IN,
  localparam int BANK_AW   = $clog2(NUM_BANKS),
  localparam int ADDR_W    = BANK_AW + WORD_AW,
  localparam int IN_W      = $clog2(NUM_IN),
  localparam int PAIR_W    = $clog2(NUM_IN / 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_en,
  input  logic              ext_we,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [DATA_W-1:0] ext_wdata,
  output logic [DATA_W-1:0] ext_rdata,
  input  logic              ctl_start,
  input  logic [PAIR_W-1:0] ctl_pair,
  output logic              ctl_busy,
  output logic              ctl_done,
  output logic [IN_W-1:0]   ctl_done_bank,
  output logic              ctl_err,
  output logic              ctl_collision
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [BANK_AW-1:0] ext_bank;
  logic [WORD_AW-1:0] ext_word;
  logic [BANK_AW-1:0] rsel_q;
  logic [DATA_W-1:0]  a_q  [NUM_BANKS];
  logic [DATA_W-1:0]  in_q [NUM_IN];

  logic               eng_rd_en, eng_wr_en;
  logic [WORD_AW-1:0] eng_rd_addr, eng_wr_addr;
  logic [DATA_W-1:0]  eng_wr_data, eng_rd_data;
  logic [IN_W-1:0]    eng_bank;
  logic               col_q, col_d, col_hit;

  assign ext_bank    = ext_addr[ADDR_W-1:WORD_AW];
  assign ext_word    = ext_addr[WORD_AW-1:0];
  assign ext_rdata   = a_q[rsel_q];
  assign eng_rd_data = in_q[eng_bank];

  coproc_engine #(
    .DATA_W (DATA_W),
    .DEPTH  (BANK_WORDS),
    .NUM_IN (NUM_IN)
  ) u_engine (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (ctl_start),
    .pair    (ctl_pair),
    .rd_data (eng_rd_data),
    .busy    (ctl_busy),
    .done    (ctl_done),
    .err     (ctl_err),
    .bank    (eng_bank),
    .rd_en   (eng_rd_en),
    .rd_addr (eng_rd_addr),
    .wr_en   (eng_wr_en),
    .wr_addr (eng_wr_addr),
    .wr_data (eng_wr_data)
  );

  assign ctl_done_bank = eng_bank;

  genvar g;
  generate
    for (g = 0; g < NUM_BANKS; g++) begin : g_bank
      logic a_en;
      assign a_en = ext_en && (ext_bank == BANK_AW'(g));
      if (g < NUM_IN) begin : g_in
        coproc_in_bank #(.DATA_W(DATA_W), .DEPTH(BANK_WORDS)) u_mem (
          .clk     (clk),
          .a_en    (a_en),
          .a_we    (ext_we),
          .a_addr  (ext_word),
          .a_wdata (ext_wdata),
          .a_rdata (a_q[g]),
          .b_en    (eng_rd_en && (eng_bank == IN_W'(g))),
          .b_addr  (eng_rd_addr),
          .b_rdata (in_q[g])
        );
      end else begin : g_out
        coproc_out_bank #(.DATA_W(DATA_W), .DEPTH(BANK_WORDS)) u_mem (
          .clk     (clk),
          .a_en    (a_en),
          .a_we    (ext_we),
          .a_addr  (ext_word),
          .a_wdata (ext_wdata),
          .a_rdata (a_q[g]),
          .b_we    (eng_wr_en && (eng_bank == IN_W'(g - NUM_IN))),
          .b_addr  (eng_wr_addr),
          .b_wdata (eng_wr_data)
        );
      end
    end
  endgenerate

  // collision detect: external write into the bank being processed
  assign col_hit = ext_en && ext_we && ctl_busy &&
                   (ext_bank == {1'b0, eng_bank});
  assign col_d   = col_q | col_hit;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      col_q  <= 1'b0;
      rsel_q <= '0;
    end else begin
      col_q <= col_d;
      if (ext_en && !ext_we) rsel_q <= ext_bank;
    end
  end

  assign ctl_collision = col_q;
endmodule

// File: rtl/coproc_buf_wrapper_chk.sv
module coproc_buf_wrapper_chk (
  input logic clk,
  input logic rst_n,
  input logic ctl_start,
  input logic ctl_busy,
  input logic ctl_done,
  input logic ctl_err,
  input logic ctl_collision
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (!ctl_busy && !ctl_done && !ctl_err && !ctl_collision)
        else $error("outputs not idle during reset");
    end
  end

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_done |-> !ctl_busy);

  assert_done_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_busy) |-> ctl_done);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_done |=> !ctl_done);

  assert_busy_needs_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_busy) |-> $past(ctl_start));

  assert_reject_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_start && ctl_busy) |=> (ctl_err && ctl_busy));

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_err && !$past(ctl_start)) |-> 1'b0);

  assert_collision_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_collision |=> ctl_collision);
endmodule

bind coproc_buf_wrapper coproc_buf_wrapper_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .ctl_start     (ctl_start),
  .ctl_busy      (ctl_busy),
  .ctl_done      (ctl_done),
  .ctl_err       (ctl_err),
  .ctl_collision (ctl_collision)
);

// File: tb/coproc_buf_wrapper_bench.sv
`timescale 1ns/1ps
module coproc_buf_wrapper_bench;
  localparam int DW = 32;
  localparam int W  = 16;
  localparam int NI = 4;
  localparam int NB = 2 * NI;
  localparam int WA = $clog2(W);
  localparam int AW = $clog2(NB) + WA;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ext_en, ext_we;
  logic [AW-1:0] ext_addr;
  logic [DW-1:0] ext_wdata, ext_rdata;
  logic          ctl_start;
  logic [0:0]    ctl_pair;
  logic          ctl_busy, ctl_done, ctl_err, ctl_collision;
  logic [1:0]    ctl_done_bank;

  int n_tests = 0;
  int n_fail  = 0;
  logic [DW-1:0] model [NB*W];

  always #4 clk = ~clk;

  coproc_buf_wrapper #(.DATA_W(DW), .BANK_WORDS(W), .NUM_IN(NI)) u_coproc_buf_wrapper (
    .clk(clk), .rst_n(rst_n),
    .ext_en(ext_en), .ext_we(ext_we), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .ctl_start(ctl_start), .ctl_pair(ctl_pair),
    .ctl_busy(ctl_busy), .ctl_done(ctl_done), .ctl_done_bank(ctl_done_bank),
    .ctl_err(ctl_err), .ctl_collision(ctl_collision)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ext_en = 0; ext_we = 0; ext_addr = '0; ext_wdata = '0;
    ctl_start = 0; ctl_pair = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic ext_write(input int a, input logic [DW-1:0] d);
    ext_en = 1; ext_we = 1; ext_addr = AW'(a); ext_wdata = d;
    @(posedge clk); @(negedge clk);
    ext_en = 0; ext_we = 0;
  endtask

  task automatic ext_read(input int a, output logic [DW-1:0] d);
    ext_en = 1; ext_we = 0; ext_addr = AW'(a);
    @(posedge clk); @(negedge clk);
    d = ext_rdata;
    ext_en = 0;
  endtask

  task automatic start_only(input int p);
    ctl_start = 1; ctl_pair = 1'(p);
    @(posedge clk); @(negedge clk);
    ctl_start = 0;
  endtask

  task automatic wait_done(output int cnt);
    cnt = 0;
    while (ctl_busy && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic apply_model(input int b);
    for (int i = 0; i < W; i++) model[(NI + b) * W + i] = model[b * W + i] + 1;
  endtask

  task automatic check_outputs(input string req);
    logic [DW-1:0] d;
    for (int a = NI * W; a < NB * W; a++) begin
      ext_read(a, d);
      chk(d == model[a], req, d, model[a]);
    end
  endtask

  task automatic run_pass(input int p, input int exp_bank);
    int cnt;
    start_only(p);
    wait_done(cnt);
    chk(cnt == W + 1, "R6 busy length", cnt, W + 1);
    chk(ctl_done == 1'b1, "R6 done at busy fall", ctl_done, 1);
    chk(ctl_done_bank == 2'(exp_bank), "R5 ping-pong bank", ctl_done_bank, exp_bank);
    @(negedge clk);
    chk(ctl_done == 1'b0, "R6 done one cycle", ctl_done, 0);
    apply_model(exp_bank);
    check_outputs("R4 R10 output banks");
  endtask

  initial begin
    #(8ns * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    int cnt;
    do_reset();
    chk(!ctl_busy && !ctl_done && !ctl_err && !ctl_collision, "R1 reset state",
        {ctl_busy, ctl_done, ctl_err, ctl_collision}, 0);

    // R2 R3: fill every word with a distinct value, then read all back
    for (int a = 0; a < NB * W; a++) model[a] = (DW'(a) * 32'h0101_0101) ^ 32'hC3A5_0000;
    model[W - 1] = 32'hFFFF_FFFF;               // wrap case in bank 0
    for (int a = 0; a < NB * W; a++) ext_write(a, model[a]);
    for (int a = 0; a < NB * W; a++) begin
      ext_read(a, d);
      chk(d == model[a], "R2 R3 flat map readback", d, model[a]);
    end

    // R4 R5 R6 R10: ping-pong on both pairs
    run_pass(0, 0);
    chk(model[NI * W + W - 1] == 32'h0, "R4 increment wraps", model[NI * W + W - 1], 0);
    run_pass(0, 1);
    run_pass(0, 0);
    run_pass(1, 2);
    run_pass(1, 3);

    // R7: start while busy is rejected, alternation unchanged
    start_only(1);                              // pair 1 -> bank 2
    ctl_start = 1; ctl_pair = 1'b0;
    @(posedge clk); @(negedge clk);
    ctl_start = 0;
    chk(ctl_err == 1'b1, "R7 err on busy start", ctl_err, 1);
    chk(ctl_busy == 1'b1, "R7 pass continues", ctl_busy, 1);
    @(negedge clk);
    chk(ctl_err == 1'b0, "R7 err one cycle", ctl_err, 0);
    wait_done(cnt);
    chk(ctl_done_bank == 2'd2, "R7 running pass kept", ctl_done_bank, 2);
    @(negedge clk);
    apply_model(2);
    check_outputs("R7 R4 outputs after reject");
    run_pass(0, 1);                             // pair 0 pointer not advanced by reject

    // R8 R9: overlap and collision during pass on bank 3
    start_only(1);                              // pair 1 -> bank 3
    model[0] = 32'h1234_5678;
    ext_write(0, model[0]);                     // idle input bank
    chk(ctl_collision == 1'b0, "R8 no collision on idle bank", ctl_collision, 0);
    ext_read(0, d);
    chk(d == model[0], "R9 overlap access", d, model[0]);
    ext_write(3 * W + 5, model[3 * W + 5]);     // same value into the active bank
    chk(ctl_collision == 1'b1, "R8 collision set", ctl_collision, 1);
    wait_done(cnt);
    chk(ctl_done_bank == 2'd3, "R5 bank 3 pass", ctl_done_bank, 3);
    @(negedge clk);
    apply_model(3);
    check_outputs("R9 R4 outputs after overlap");
    chk(ctl_collision == 1'b1, "R8 collision sticky", ctl_collision, 1);

    do_reset();
    chk(!ctl_busy && !ctl_collision && !ctl_err, "R1 reset clears flags",
        {ctl_busy, ctl_collision, ctl_err}, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule